// File: doc/BRIEF.md
# Write-to-Precharge Timing Guard

This block watches the command stream of a DDR2 memory controller and enforces, bank by bank, the minimum spacing between a write and a later precharge of the same bank. A write blocks precharge until three things have passed: the write latency, the cycles the burst spends on the data bus, and the write-recovery time. Because the recovery time is counted from the end of the data burst, a precharge can never cut a burst short. The scheduler reads one precharge-allowed flag per bank. A separate violation report catches any precharge or precharge-all that still arrives too early.

The write latency comes from a configured read latency, one cycle less. The burst-length setting picks two data-bus cycles for a burst of four and four cycles for every other setting. The recovery count is a clock-cycle figure that the controller converts from a time. It is kept apart from the recovery field of the mode register. Each bank has its own down-counter, so traffic to one bank never delays another.

Top module: `wr_pre_guard`

## Requirements
- R1: While `rst` is high at a rising clock edge, every `pre_ok` bit becomes 1 and `viol_pulse`, `viol_sticky`, `viol_bank` and `viol_all` become 0.
- R2: With window N = (cfg_rl - 1) + H + cfg_twr, a precharge to a bank issued k cycles after a write to that bank is legal when k >= N and a violation when k < N. For cfg_rl = 4, a burst of four and cfg_twr = 3, the first legal k is 8. For cfg_rl = 5 it is 9. A cfg_rl of 0 is taken as a write latency of 0.
- R3: H is 2 when `cfg_bl` equals 4 and 4 for any other value of `cfg_bl`, including 8.
- R4: `pre_ok[b]` is 0 in the cycle after a write to bank b is sampled. It stays 0 until the edge of cycle k = N, where it returns to 1.
- R5: A new write to a bank whose window is still open restarts that bank's window in full from the new write.
- R6: Each bank's window depends only on writes to that bank.
- R7: A precharge-all is legal only when every bank is idle. An early precharge-all raises a violation with `viol_all` = 1 and `viol_bank` set to the lowest-numbered busy bank.
- R8: An early single-bank precharge raises `viol_pulse` for exactly the one cycle after it, with `viol_bank` = the command's bank and `viol_all` = 0. `viol_sticky` rises with the first violation and stays 1 until reset.
- R9: Precharge commands, legal or not, and other commands leave every bank's window unchanged.
- R10: `cmd_kind` codes are 2'b01 write, 2'b10 precharge, 2'b11 precharge-all and 2'b00 any other command. A command with `cmd_valid` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | Command code (see R10) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cfg_rl | input | LAT_W | Configured read latency in cycles |
| cfg_bl | input | BL_W | Burst-length setting (4, otherwise treated as 8) |
| cfg_twr | input | TWR_W | Write-recovery count in cycles |
| pre_ok | output | NUM_BANKS | Per-bank precharge allowed |
| viol_pulse | output | 1 | One-cycle pulse for an early precharge |
| viol_sticky | output | 1 | Latched violation, cleared by reset |
| viol_bank | output | $clog2(NUM_BANKS) | Bank of the last violation |
| viol_all | output | 1 | Last violation came from a precharge-all |

## Verification
The hardest edge to reach is the exact boundary cycle k = N - 1 versus k = N. It must be hit for every latency, burst and recovery combination, not only for the example settings. The bench sweeps read latency 2 to 6, three burst settings and recovery 0 to 4. For each combination it issues a precharge at every distance from 1 to N + 1 after a write, rotating the target bank. Directed sequences cover the other cases: a rewrite that lands mid-window, overlapping windows on several banks, and a precharge-all while banks are busy. Each of these is checked against an arithmetic model in the bench.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER  = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_PRE    = 2'b10,
    CMD_PREALL = 2'b11
  } wpg_cmd_e;
endpackage

// File: rtl/wpg_window_calc.sv
module wpg_window_calc #(
  parameter int LAT_W = 4,
  parameter int TWR_W = 4,
  parameter int BL_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic [LAT_W-1:0] cfg_rl,
  input  logic [BL_W-1:0]  cfg_bl,
  input  logic [TWR_W-1:0] cfg_twr,
  output logic [CNT_W-1:0] load_val
);
  logic [CNT_W-1:0] rl_x, wl_x, half_x, twr_x;

  always_comb begin
    rl_x   = CNT_W'(cfg_rl);
    twr_x  = CNT_W'(cfg_twr);
    // write latency trails read latency by one; clamp at zero
    wl_x   = (rl_x == '0) ? '0 : rl_x - CNT_W'(1);
    // two beats per clock: BL4 -> 2 cycles, anything else -> BL8 -> 4 cycles
    half_x = (cfg_bl == BL_W'(4)) ? CNT_W'(2) : CNT_W'(4);
    // counter is loaded at the write edge, so it holds N-1 afterwards
    load_val = wl_x + half_x + twr_x - CNT_W'(1);
  end

  // R2: the window is never empty, so a write always blocks at least one cycle
  always_comb begin
    a_r2_window_nonzero: assert (load_val != '0);
  end
endmodule

// File: rtl/wpg_bank_timer.sv
module wpg_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] load_val,
  output logic             ok_q
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
    end else if (wr_hit) begin
      cnt_q <= load_val;
      ok_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      ok_q  <= (cnt_q == CNT_W'(1));
    end
  end

  // R4: a write to this bank blocks precharge on the next cycle
  a_r4_write_blocks: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !ok_q);

  // R9: without a write, a running window only counts down by one
  a_r9_steady_count: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wpg_violation.sv
module wpg_violation
  import wpg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  wpg_cmd_e             cmd_kind,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [NUM_BANKS-1:0] busy,
  output logic                 viol_pulse,
  output logic                 viol_sticky,
  output logic [BANK_W-1:0]    viol_bank,
  output logic                 viol_all
);
  logic [BANK_W-1:0] low_idx;
  logic              pre_hit, all_hit;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (busy[i]) low_idx = BANK_W'(i);
    end
    pre_hit = cmd_valid && (cmd_kind == CMD_PRE) && busy[cmd_bank];
    all_hit = cmd_valid && (cmd_kind == CMD_PREALL) && (|busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
      viol_bank   <= '0;
      viol_all    <= 1'b0;
    end else begin
      viol_pulse  <= pre_hit | all_hit;
      viol_sticky <= viol_sticky | pre_hit | all_hit;
      if (pre_hit) begin
        viol_bank <= cmd_bank;
        viol_all  <= 1'b0;
      end else if (all_hit) begin
        viol_bank <= low_idx;
        viol_all  <= 1'b1;
      end
    end
  end

  // R8: once set, the latched flag survives until reset
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    viol_sticky |=> viol_sticky);

  // R8: every pulse is mirrored in the latched flag
  a_r8_pulse_latched: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_sticky);

  // R7: precharge-all with all banks idle is clean
  a_r7_all_idle_clean: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CMD_PREALL && busy == '0) |=> !viol_pulse);
endmodule

// File: rtl/wr_pre_guard.sv
module wr_pre_guard
  import wpg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LAT_W     = 4,
  parameter int TWR_W     = 4,
  parameter int BL_W      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = ((LAT_W > TWR_W) ? LAT_W : TWR_W) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_kind,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [LAT_W-1:0]     cfg_rl,
  input  logic [BL_W-1:0]      cfg_bl,
  input  logic [TWR_W-1:0]     cfg_twr,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic                 viol_pulse,
  output logic                 viol_sticky,
  output logic [BANK_W-1:0]    viol_bank,
  output logic                 viol_all
);
  wpg_cmd_e         kind;
  logic [CNT_W-1:0] load_val;
  logic             is_write;

  assign kind     = wpg_cmd_e'(cmd_kind);
  assign is_write = cmd_valid && (kind == CMD_WRITE);

  wpg_window_calc #(
    .LAT_W(LAT_W), .TWR_W(TWR_W), .BL_W(BL_W), .CNT_W(CNT_W)
  ) calc_i (
    .cfg_rl(cfg_rl), .cfg_bl(cfg_bl), .cfg_twr(cfg_twr), .load_val(load_val)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    wpg_bank_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk),
      .rst(rst),
      .wr_hit(is_write && (cmd_bank == BANK_W'(g))),
      .load_val(load_val),
      .ok_q(pre_ok[g])
    );
  end

  wpg_violation #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) viol_i (
    .clk(clk),
    .rst(rst),
    .cmd_valid(cmd_valid),
    .cmd_kind(kind),
    .cmd_bank(cmd_bank),
    .busy(~pre_ok),
    .viol_pulse(viol_pulse),
    .viol_sticky(viol_sticky),
    .viol_bank(viol_bank),
    .viol_all(viol_all)
  );

  // R10: an idle command slot never produces a violation
  a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !viol_pulse);

  // R6: a write touches only its own bank's flag
  a_r6_other_banks: assert property (@(posedge clk) disable iff (rst)
    (is_write && pre_ok[0] && cmd_bank != BANK_W'(0)) |=> pre_ok[0]);
endmodule

// File: tb/wr_pre_guard_tb.sv
module wr_pre_guard_tb_top;
  localparam int NB = 4;
  localparam int LW = 4;
  localparam int TW = 4;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = 2'b00;
  logic [1:0]    cmd_bank = 2'b00;
  logic [LW-1:0] cfg_rl = 4'd4;
  logic [BW-1:0] cfg_bl = 4'd4;
  logic [TW-1:0] cfg_twr = 4'd3;
  logic [NB-1:0] pre_ok;
  logic          viol_pulse, viol_sticky, viol_all;
  logic [1:0]    viol_bank;

  int checks = 0;
  int errors = 0;
  int rem [NB];
  bit exp_sticky = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wr_pre_guard #(.NUM_BANKS(NB), .LAT_W(LW), .TWR_W(TW), .BL_W(BW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cfg_rl(cfg_rl), .cfg_bl(cfg_bl), .cfg_twr(cfg_twr),
    .pre_ok(pre_ok), .viol_pulse(viol_pulse), .viol_sticky(viol_sticky),
    .viol_bank(viol_bank), .viol_all(viol_all)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int win_n();
    int wl = (cfg_rl == 0) ? 0 : int'(cfg_rl) - 1;
    int h  = (cfg_bl == 4) ? 2 : 4;
    return wl + h + int'(cfg_twr);
  endfunction

  // call at a negedge; returns at the next negedge after checking outputs
  task automatic step(input bit v, input int kind, input int bank, input string tag);
    bit ep = 0;
    int eb = 0;
    bit ea = 0;
    if (v && kind == 2) begin
      ep = (rem[bank] != 0);
      eb = bank;
    end else if (v && kind == 3) begin
      for (int b = NB - 1; b >= 0; b--) if (rem[b] != 0) begin ep = 1; eb = b; end
      ea = 1;
    end
    cmd_valid = v;
    cmd_kind  = 2'(kind);
    cmd_bank  = 2'(bank);
    for (int b = 0; b < NB; b++) begin
      if (v && kind == 1 && b == bank) rem[b] = win_n() - 1;
      else if (rem[b] > 0) rem[b]--;
    end
    if (ep) exp_sticky = 1;
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) chk({tag, " pre_ok"}, int'(pre_ok[b]), int'(rem[b] == 0));
    chk({tag, " viol_pulse"}, int'(viol_pulse), int'(ep));
    chk({tag, " viol_sticky"}, int'(viol_sticky), int'(exp_sticky));
    if (ep) begin
      chk({tag, " viol_bank"}, int'(viol_bank), eb);
      chk({tag, " viol_all"}, int'(viol_all), int'(ea));
    end
    cmd_valid = 1'b0;
    cmd_kind  = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) rem[b] = 0;
    exp_sticky = 0;
    // R1: reset state
    chk("R1 pre_ok", int'(pre_ok), (1 << NB) - 1);
    chk("R1 viol_pulse", int'(viol_pulse), 0);
    chk("R1 viol_sticky", int'(viol_sticky), 0);
    chk("R1 viol_bank", int'(viol_bank), 0);
    chk("R1 viol_all", int'(viol_all), 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 1, 0, tag);
  endtask

  // write to bank, then precharge k cycles later; expects legality iff k >= N
  task automatic probe(input int bank, input int k, input string tag);
    step(1, 1, bank, tag);
    idle(k - 1, tag);
    step(1, 2, bank, tag);
  endtask

  initial begin
    // directed example windows, R2
    do_reset();
    cfg_rl = 4; cfg_bl = 4; cfg_twr = 3;
    chk("R2 window rl4", win_n(), 8);
    probe(0, 7, "R2 rl4 k7");
    chk("R2 early at 7", int'(viol_pulse), 1);
    idle(10, "R2");
    probe(1, 8, "R2 rl4 k8");
    chk("R2 legal at 8", int'(viol_pulse), 0);
    idle(10, "R2");
    cfg_rl = 5;
    chk("R2 window rl5", win_n(), 9);
    probe(2, 8, "R2 rl5 k8");
    idle(12, "R2");
    probe(3, 9, "R2 rl5 k9");
    chk("R2 legal at 9", int'(viol_pulse), 0);
    idle(12, "R2");

    // sweep of all configurations, R2 R3 R4 R8
    for (int rl = 2; rl <= 6; rl++) begin
      for (int bi = 0; bi < 3; bi++) begin
        for (int tw = 0; tw <= 4; tw++) begin
          do_reset();
          cfg_rl = 4'(rl);
          cfg_bl = (bi == 0) ? 4'd4 : ((bi == 1) ? 4'd8 : 4'd5);
          cfg_twr = 4'(tw);
          for (int k = 1; k <= win_n() + 1; k++) begin
            probe(k % NB, k, "R2 R3 R4 R8 sweep");
            idle(win_n(), "R4 drain");
          end
        end
      end
    end

    // R5: rewrite mid-window restarts the window
    do_reset();
    cfg_rl = 4; cfg_bl = 8; cfg_twr = 2;
    step(1, 1, 0, "R5");
    idle(2, "R5");
    step(1, 1, 0, "R5 rewrite");
    idle(win_n() - 3, "R5");
    step(1, 2, 0, "R5 first-window end");
    chk("R5 still blocked", int'(viol_pulse), 1);
    idle(2, "R5");
    step(1, 2, 0, "R5 second-window end");
    chk("R5 legal after reload", int'(viol_pulse), 0);

    // R6 + R9: overlapping banks, early precharges and other commands
    do_reset();
    cfg_rl = 3; cfg_bl = 4; cfg_twr = 4;
    step(1, 1, 1, "R6");
    step(1, 2, 1, "R9 early pre");
    step(1, 1, 2, "R6");
    step(1, 0, 2, "R9 other cmd");
    step(1, 2, 3, "R6 idle bank pre");
    chk("R6 idle bank clean", int'(viol_pulse), 0);
    step(0, 1, 3, "R10 invalid write");
    chk("R10 bank3 untouched", int'(pre_ok[3]), 1);
    step(0, 2, 2, "R10 invalid pre");
    chk("R10 no pulse", int'(viol_pulse), 0);
    idle(12, "R9");

    // R7: precharge-all busy and idle
    step(1, 1, 3, "R7");
    step(1, 1, 2, "R7");
    step(1, 3, 0, "R7 early all");
    chk("R7 all flagged", int'(viol_all), 1);
    chk("R7 lowest busy", int'(viol_bank), 2);
    idle(2, "R7");
    step(1, 2, 3, "R8 single after all");
    chk("R8 single clears all", int'(viol_all), 0);
    idle(12, "R7");
    step(1, 3, 0, "R7 idle all");
    chk("R7 idle legal", int'(viol_pulse), 0);
    chk("R8 sticky kept", int'(viol_sticky), 1);

    // R3: boundary for cfg_bl = 0 and 15 behaves as BL8
    do_reset();
    cfg_rl = 2; cfg_twr = 1;
    cfg_bl = 0;
    probe(0, 5, "R3 bl0 k5");
    chk("R3 bl0 window 6", int'(viol_pulse), 1);
    idle(8, "R3");
    cfg_bl = 15;
    probe(0, 6, "R3 bl15 k6");
    chk("R3 bl15 legal", int'(viol_pulse), 0);

    // R2: read latency 0 clamps write latency at 0
    do_reset();
    cfg_rl = 0; cfg_bl = 4; cfg_twr = 0;
    probe(1, 1, "R2 rl0 k1");
    chk("R2 rl0 early", int'(viol_pulse), 1);
    idle(3, "R2");
    probe(1, 2, "R2 rl0 k2");
    chk("R2 rl0 legal", int'(viol_pulse), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule